// File: doc/BRIEF.md
# Flash Busy-Status Read Path

This block produces the word a reader sees on the data bus of a flash device that runs its word program and erase operations internally. When idle, it passes through the word read from the array. In identification mode, it returns a fixed manufacturer or device code instead. While an internal operation runs, it replaces the array word with a status word. Software polls this status word to learn when the operation has finished.

The operation sequencer in the block holds the busy state for a fixed number of clock cycles, set by a parameter for each operation type. A start request that arrives while an operation is running is dropped. In the status word, bit 7 is a data-polling bit: it carries the inverse of bit 7 of the word being programmed, or 0 during an erase. Bit 6 is a toggle bit that changes once per new read strobe. All other status bits read as 0.

Top module: `flash_status_poll`

## Requirements
- R1: During and straight after reset, `busy` is 0 and `rd_data` equals `array_data`.
- R2: A start sampled at a clock edge while idle makes `busy` 1 from that edge for exactly PROG_CYCLES clock cycles for a program, or ERASE_CYCLES cycles for an erase. If `start_prog` and `start_erase` are both high, the program wins.
- R3: Start requests sampled while `busy` is 1 are ignored. They change neither the remaining busy time nor the operation type.
- R4: While a program is busy, `rd_data[7]` is the inverse of the `prog_bit7` value sampled with the accepted start.
- R5: While an erase is busy, `rd_data[7]` is 0.
- R6: While busy, `rd_data[6]` is 0 when the operation starts. It inverts once for each rising edge of `rd_stb` sampled at a clock edge while busy, and becomes visible after that edge. Holding `rd_stb` high causes no further change.
- R7: While busy, `rd_data` bits 15:8 and 5:0 are 0.
- R8: When idle with `id_mode` = 1, `rd_data` is 0x001F when `rd_a0` = 0 and 0x0092 when `rd_a0` = 1.
- R9: Busy status takes priority over identification mode. When the operation ends, reads return to the idle behaviour in the cycle after the last busy cycle.
- R10: When idle with `id_mode` = 0, `rd_data` equals `array_data`, and `rd_stb` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_prog | input | 1 | Request to start a word program |
| start_erase | input | 1 | Request to start an erase |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed, sampled with the start |
| id_mode | input | 1 | Identification mode select |
| rd_a0 | input | 1 | Read address bit 0, selects the identification code |
| rd_stb | input | 1 | Read strobe; its rising edges advance the toggle bit |
| array_data | input | DW | True word read from the array |
| rd_data | output | DW | Word presented to the reader |
| busy | output | 1 | Internal operation in progress |

## Verification
The data mux is combinational, so identification codes and array pass-through are due in the same cycle as their inputs. The bench settles them 1 ns after the falling edge at which it drives them. `busy`, the operation type, bit 7 and the toggle bit are registered: each takes effect one edge after the start or strobe is sampled. The bench's model therefore updates its expected state at that edge, using the inputs as they stood just before it. The busy window is counted in rising edges from the accepting edge. The bench compares the number of cycles it observes with the parameter.

// File: rtl/flash_status_poll.sv
module flash_status_poll #(
  parameter int DW           = 16,
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 100,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'h92
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic          prog_bit7,
  input  logic          id_mode,
  input  logic          rd_a0,
  input  logic          rd_stb,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          is_erase;
  logic          poll_bit;
  logic          tgl;
  logic          stb_q;
  logic [DW-1:0] status_w;
  logic [DW-1:0] id_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      is_erase <= 1'b0;
      poll_bit <= 1'b0;
      tgl      <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= rd_stb;
      if (!busy) begin
        if (start_prog) begin
          busy     <= 1'b1;
          cnt      <= PROG_LAST;
          is_erase <= 1'b0;
          poll_bit <= ~prog_bit7;
          tgl      <= 1'b0;
        end else if (start_erase) begin
          busy     <= 1'b1;
          cnt      <= ERASE_LAST;
          is_erase <= 1'b1;
          poll_bit <= 1'b0;
          tgl      <= 1'b0;
        end
      end else begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
        if (rd_stb && !stb_q) tgl <= ~tgl;
      end
    end
  end

  always_comb begin
    status_w    = '0;
    status_w[7] = poll_bit & ~is_erase;
    status_w[6] = tgl;
  end

  assign id_w    = {{(DW-8){1'b0}}, (rd_a0 ? DEV_CODE : MFR_CODE)};
  assign rd_data = busy ? status_w : (id_mode ? id_w : array_data);

endmodule

module flash_status_poll_chk #(
  parameter int DW           = 16,
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_prog,
  input logic          start_erase,
  input logic          rd_stb,
  input logic          busy,
  input logic [DW-1:0] rd_data
);
  int run_len;
  int exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
      exp_len <= 0;
    end else begin
      if (!busy && (start_prog || start_erase))
        exp_len <= start_prog ? PROG_CYCLES : ERASE_CYCLES;
      run_len <= busy ? run_len + 1 : 0;
    end
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == exp_len); // R2
  AST_BUSY_NOT_PAST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < exp_len); // R3
  AST_POLL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rd_data[7])); // R4
  AST_TGL_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rd_data[6] == 1'b0); // R6
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(busy, 2) && $past(rd_stb) && !$past(rd_stb, 2)
      |-> rd_data[6] != $past(rd_data[6])); // R6
  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !($past(rd_stb) && !$past(rd_stb, 2))
      |-> $stable(rd_data[6])); // R6
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_data[DW-1:8] == '0 && rd_data[5:0] == '0); // R7
endmodule

bind flash_status_poll flash_status_poll_chk #(
  .DW(DW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
  .rd_stb(rd_stb), .busy(busy), .rd_data(rd_data)
);

// File: tb/flash_status_poll_tb.sv
module flash_status_poll_tb_top;
  localparam int P = 40;
  localparam int E = 100;

  logic clk = 1'b0;
  logic rst_n, start_prog, start_erase, prog_bit7, id_mode, rd_a0, rd_stb;
  logic [15:0] array_data, rd_data;
  logic busy;

  flash_status_poll #(.DW(16), .PROG_CYCLES(P), .ERASE_CYCLES(E)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .prog_bit7(prog_bit7), .id_mode(id_mode), .rd_a0(rd_a0), .rd_stb(rd_stb),
    .array_data(array_data), .rd_data(rd_data), .busy(busy)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, left = 0, obs = 0;
  bit m_erase = 0, m_b7 = 0, m_tgl = 0, stb_prev = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] id_code(input logic a0);
    return a0 ? 16'h0092 : 16'h001F;
  endfunction

  task automatic check_outputs();
    logic [15:0] e;
    chk(busy === (left > 0), "R2", {15'd0, busy}, {15'd0, left > 0});
    if (left > 0) begin
      chk(rd_data[7] === (m_erase ? 1'b0 : ~m_b7), m_erase ? "R5" : "R4",
          {15'd0, rd_data[7]}, {15'd0, (m_erase ? 1'b0 : ~m_b7)});
      chk(rd_data[6] === m_tgl, "R6", {15'd0, rd_data[6]}, {15'd0, m_tgl});
      chk({rd_data[15:8], rd_data[5:0]} === 14'd0, id_mode ? "R9" : "R7",
          rd_data & 16'hFF3F, 16'h0000);
    end else if (id_mode) begin
      e = id_code(rd_a0);
      chk(rd_data === e, "R8", rd_data, e);
    end else begin
      chk(rd_data === array_data, "R10", rd_data, array_data);
    end
  endtask

  task automatic tick();
    bit wb, rise, acc, sp;
    wb = left > 0;
    rise = rd_stb && !stb_prev;
    stb_prev = rd_stb;
    acc = !wb && (start_prog || start_erase);
    sp = start_prog;
    @(negedge clk);
    if (wb) begin
      left--;
      if (rise) m_tgl = ~m_tgl;
    end
    if (acc) begin
      left = sp ? P : E;
      m_erase = !sp;
      m_b7 = prog_bit7;
      m_tgl = 1'b0;
    end
    if (busy === 1'b1) obs++;
    array_data = 16'($urandom);
    rd_a0 = 1'($urandom);
    #1;
    check_outputs();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start_prog = 0; start_erase = 0; prog_bit7 = 0;
    id_mode = 0; rd_a0 = 0; rd_stb = 0; array_data = 16'hA5C3;
    repeat (2) @(negedge clk);
    #1;
    chk(busy === 1'b0, "R1", {15'd0, busy}, 16'd0);
    chk(rd_data === 16'hA5C3, "R1", rd_data, 16'hA5C3);
    rst_n = 1;
    tick();
    chk(rd_data === array_data, "R1", rd_data, array_data);

    // program with bit7 = 1, strobe patterns and a stray start while busy
    prog_bit7 = 1; start_prog = 1; tick(); start_prog = 0; prog_bit7 = 0;
    obs = 1;
    rd_stb = 1; tick(); rd_stb = 0; tick();
    rd_stb = 1; repeat (4) tick(); rd_stb = 0; tick();
    start_erase = 1; tick(); start_erase = 0;
    start_prog = 1; tick(); start_prog = 0;
    rd_stb = 1; tick(); rd_stb = 0;
    while (left > 0) tick();
    chk(obs == P, "R3", 16'(obs), 16'(P));
    chk(busy === 1'b0, "R3", {15'd0, busy}, 16'd0);

    // erase with id mode active during busy
    id_mode = 1;
    start_erase = 1; tick(); start_erase = 0;
    obs = 1;
    repeat (5) begin rd_stb = 1; tick(); rd_stb = 0; tick(); end
    while (left > 0) tick();
    chk(obs == E, "R2", 16'(obs), 16'(E));
    tick();
    chk(rd_data === id_code(rd_a0), "R9", rd_data, id_code(rd_a0));
    id_mode = 0;

    // both starts together: program wins
    prog_bit7 = 0; start_prog = 1; start_erase = 1; tick();
    start_prog = 0; start_erase = 0;
    chk(rd_data[7] === 1'b1, "R2", {15'd0, rd_data[7]}, 16'd1);
    chk(left == P, "R2", 16'(left), 16'(P));
    while (left > 0) tick();

    // idle: strobe has no effect, identification codes
    repeat (6) begin rd_stb = ~rd_stb; tick(); end
    rd_stb = 0; id_mode = 1;
    repeat (6) tick();
    id_mode = 0;

    // constrained random operations
    for (int i = 0; i < 40; i++) begin
      prog_bit7 = 1'($urandom);
      if ($urandom % 2) start_prog = 1; else start_erase = 1;
      tick();
      start_prog = 0; start_erase = 0;
      while (left > 0) begin
        rd_stb = 1'($urandom);
        id_mode = ($urandom % 4) == 0;
        if (($urandom % 16) == 0) start_erase = 1;
        if (($urandom % 16) == 0) start_prog = 1;
        tick();
        start_prog = 0; start_erase = 0;
      end
      rd_stb = 0;
      id_mode = 1'($urandom);
      repeat (3) tick();
      id_mode = 0;
    end

    done = 1;
    summary();
    $finish;
  end
endmodule